// File: doc/BRIEF.md
# Bridge Channel Interrupt and Control Registers

This block is the control-register side of a host bridge that serves up to four byte-wide CAN controller channels. Each channel raises a level interrupt. The block latches it into a pending bit in a 16-bit status field, and the host clears that bit by writing 1 to it. A 16-bit enable field selects which pending bits reach the single host interrupt output. The channels do not map to consecutive bits. Channel 0 is bit 1, channel 1 is bit 0, channel 2 is bit 6 and channel 3 is bit 7. The same bit positions apply in both fields.

Two further registers complete the block. The first is a 32-bit general-purpose IO control word, which drives an output bus to the board. The second is a 32-bit miscellaneous word whose top byte controls the channel reset line and the parallel-port multiplexing mode. A small state machine holds the reset line. Its state `RST_HOLD` drives the reset high, and its state `RST_RUN` releases it. A top-byte write with bit 0 set takes the transition RUN→HOLD, or keeps the machine in HOLD. A top-byte write with bit 0 clear takes the transition HOLD→RUN, or keeps the machine in RUN. Any other cycle leaves the state unchanged. Power-on reset enters `RST_HOLD`.

The register bus carries 32-bit words with per-byte write enables, so byte and halfword writes are both possible. Reads are combinational from the word address. The parameter `NUM_CH` (1 to 4) sets how many channels are populated.

Top module: `bridge_irq_ctrl`

## Requirements
- R1: A high `chan_irq[c]` on a populated channel sets its status bit on the next clock edge. The bit positions are channel 0 → bit 1, channel 1 → bit 0, channel 2 → bit 6 and channel 3 → bit 7, in the status field `reg_rdata[15:0]` of word address 0 (byte offset 0x00).
- R2: Writing word 0 with byte enables 0/1 clears each status bit whose write-data bit is 1, and leaves the bits written 0 untouched. If the channel input is high in the same cycle, the bit stays set, because set has priority over clear.
- R3: The enable field is `reg_rdata[31:16]` of word 0 (byte offset 0x02). It is read/write through byte enables 2/3. The enable bits of unpopulated channels always read 0.
- R4: `host_irq` is high exactly when some status bit and its enable bit are both 1. It falls in the cycle after the last such pending bit is cleared.
- R5: The `chan_irq` input of an unpopulated channel never sets any status bit.
- R6: The GPIO control word is at word address 6 (byte offset 0x18). It is read/write per byte lane and is driven on `gpio_ctrl`.
- R7: The miscellaneous word is at word address 7 (byte offset 0x1C). A write to byte lane 3 with bit 24 set enters `RST_HOLD` (`chan_reset`=1), and one with bit 24 clear enters `RST_RUN` (`chan_reset`=0). For example, 0x05 holds the reset and 0x04 releases it.
- R8: `mux_mode` is 1 while bit 26 of the miscellaneous word is 0. Writing 0x04 to lane 3 therefore leaves mux mode.
- R9: After reset, all registers read 0 except the miscellaneous word, which reads 0x01000000. At the same point `chan_reset`=1, `mux_mode`=1 and `host_irq`=0.
- R10: Word addresses 1 to 5 read 0, and writes to them change no register.
- R11: A write changes only the byte lanes whose `reg_be` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_addr | input | 3 | Word address, i.e. byte-offset bits 4:2 |
| reg_be | input | 4 | Byte-lane write enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| chan_irq | input | 4 | Level interrupt from each channel |
| host_irq | output | 1 | Combined masked interrupt to the host |
| gpio_ctrl | output | 32 | GPIO control word |
| chan_reset | output | 1 | Reset to the channel controllers, active high |
| mux_mode | output | 1 | Parallel-port multiplexing mode active |

## Verification
The bench aims at four corner cases.

- **Channel bit mapping.** Each channel is asserted alone. A design that used contiguous bits, or swapped channels 0 and 1, would show the wrong status bit.
- **Clear while the source is still high.** A clear is issued while the channel input stays high. A design where clear won would drop the pending bit and lose an interrupt.
- **Unpopulated channels.** The bench drives the interrupt of an absent channel and tries to write its enable bit. A design that ignored the population count would raise `host_irq` from a channel that does not exist.
- **Lane-by-lane access.** The reset byte, the unmapped words and partial byte enables are exercised against a bench model. A design with a wrong lane decode would corrupt neighbouring bytes or drop the reset at the wrong time.

// File: rtl/bridge_ctl_pkg.sv
`timescale 1ns/1ps
package bridge_ctl_pkg;
    localparam int MAX_CH = 4;
    localparam int FIELD_W = 16;
    localparam logic [2:0] WORD_IRQ  = 3'd0;
    localparam logic [2:0] WORD_GPIO = 3'd6;
    localparam logic [2:0] WORD_MISC = 3'd7;

    typedef enum logic [0:0] {RST_HOLD = 1'b0, RST_RUN = 1'b1} rst_state_e;

    // status/enable bit used by a channel
    function automatic int chan_bit(input int ch);
        case (ch)
            0:       return 1;
            1:       return 0;
            2:       return 6;
            default: return 7;
        endcase
    endfunction

    // channel owning a field bit, -1 when none
    function automatic int bit_chan(input int b);
        for (int c = 0; c < MAX_CH; c++)
            if (chan_bit(c) == b) return c;
        return -1;
    endfunction

    // mask of field bits used by the first n channels
    function automatic logic [FIELD_W-1:0] pop_mask(input int n);
        logic [FIELD_W-1:0] m;
        m = '0;
        for (int c = 0; c < n; c++) m[chan_bit(c)] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/irq_unit.sv
`timescale 1ns/1ps
module irq_unit
    import bridge_ctl_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MAX_CH-1:0]  chan_irq,
    input  logic [FIELD_W-1:0] clr_mask,
    input  logic [1:0]         en_lane_we,
    input  logic [FIELD_W-1:0] en_wdata,
    output logic [FIELD_W-1:0] status,
    output logic [FIELD_W-1:0] enable,
    output logic               irq_out
);
    localparam logic [FIELD_W-1:0] POP     = pop_mask(NUM_CH);
    localparam logic [FIELD_W-1:0] ALL_CH  = pop_mask(MAX_CH);
    localparam logic [FIELD_W-1:0] EN_KEEP = ~(ALL_CH & ~POP);

    logic [FIELD_W-1:0] st_q;
    logic [FIELD_W-1:0] en_q;
    logic [FIELD_W-1:0] en_d;

    for (genvar b = 0; b < FIELD_W; b++) begin : g_bit
        if (POP[b]) begin : g_live
            localparam int CH = bit_chan(b);
            always_ff @(posedge clk) begin
                if (!rst_n) st_q[b] <= 1'b0;
                else        st_q[b] <= chan_irq[CH] | (st_q[b] & ~clr_mask[b]);
            end
            AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                chan_irq[CH] |=> st_q[b]); // R2
            AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_mask[b] && !chan_irq[CH]) |=> !st_q[b]); // R2
        end else begin : g_dead
            assign st_q[b] = 1'b0;
        end
    end

    always_comb begin
        en_d = en_q;
        if (en_lane_we[0]) en_d[7:0]  = en_wdata[7:0];
        if (en_lane_we[1]) en_d[15:8] = en_wdata[15:8];
        en_d = en_d & EN_KEEP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign status  = st_q;
    assign enable  = en_q;
    assign irq_out = |(st_q & en_q & POP);

    AST_NO_GHOST_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_lane_we != 2'b00) |=> ((enable & ALL_CH & ~POP) == '0)); // R3
endmodule

// File: rtl/ctl_regs.sv
`timescale 1ns/1ps
module ctl_regs
    import bridge_ctl_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter logic [31:0] MISC_RST = 32'h0100_0000,
    parameter int          RST_BIT  = 24,
    parameter int          MUX_BIT  = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W/8-1:0] gpio_we,
    input  logic [DATA_W/8-1:0] misc_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] gpio_q,
    output logic [DATA_W-1:0] misc_q,
    output logic              chan_reset,
    output logic              mux_mode
);
    localparam int LANES    = DATA_W / 8;
    localparam int RST_LANE = RST_BIT / 8;

    rst_state_e state_q, state_d;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gpio_q[l*8 +: 8] <= '0;
                misc_q[l*8 +: 8] <= MISC_RST[l*8 +: 8];
            end else begin
                if (gpio_we[l]) gpio_q[l*8 +: 8] <= wdata[l*8 +: 8];
                if (misc_we[l]) misc_q[l*8 +: 8] <= wdata[l*8 +: 8];
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RST_HOLD: if (misc_we[RST_LANE] && !wdata[RST_BIT]) state_d = RST_RUN;
            RST_RUN:  if (misc_we[RST_LANE] &&  wdata[RST_BIT]) state_d = RST_HOLD;
            default:  state_d = RST_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RST_HOLD;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        chan_reset = (state_q == RST_HOLD);
        mux_mode   = ~misc_q[MUX_BIT];
    end

    AST_RESET_ENTERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (misc_we[RST_LANE] && wdata[RST_BIT]) |=> chan_reset); // R7
    AST_RESET_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (misc_we[RST_LANE] && !wdata[RST_BIT]) |=> !chan_reset); // R7
    AST_MUX_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (misc_we[MUX_BIT/8] && wdata[MUX_BIT]) |=> !mux_mode); // R8
    AST_RESET_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !misc_we[RST_LANE] |=> $stable(chan_reset)); // R7
endmodule

// File: rtl/bridge_irq_ctrl.sv
`timescale 1ns/1ps
module bridge_irq_ctrl
    import bridge_ctl_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [4:2]  reg_addr,
    input  logic [3:0]  reg_be,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [3:0]  chan_irq,
    output logic        host_irq,
    output logic [31:0] gpio_ctrl,
    output logic        chan_reset,
    output logic        mux_mode
);
    logic               hit_irq, hit_gpio, hit_misc;
    logic [FIELD_W-1:0] clr_mask;
    logic [FIELD_W-1:0] st_w, en_w;
    logic [31:0]        gpio_w, misc_w;

    assign hit_irq  = reg_we && (reg_addr == WORD_IRQ);
    assign hit_gpio = reg_we && (reg_addr == WORD_GPIO);
    assign hit_misc = reg_we && (reg_addr == WORD_MISC);

    assign clr_mask = {reg_be[1] ? reg_wdata[15:8] : 8'h00,
                       reg_be[0] ? reg_wdata[7:0]  : 8'h00} & {FIELD_W{hit_irq}};

    irq_unit #(.NUM_CH(NUM_CH)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_irq   (chan_irq),
        .clr_mask   (clr_mask),
        .en_lane_we (reg_be[3:2] & {2{hit_irq}}),
        .en_wdata   (reg_wdata[31:16]),
        .status     (st_w),
        .enable     (en_w),
        .irq_out    (host_irq)
    );

    ctl_regs u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .gpio_we    (reg_be & {4{hit_gpio}}),
        .misc_we    (reg_be & {4{hit_misc}}),
        .wdata      (reg_wdata),
        .gpio_q     (gpio_w),
        .misc_q     (misc_w),
        .chan_reset (chan_reset),
        .mux_mode   (mux_mode)
    );

    assign gpio_ctrl = gpio_w;

    always_comb begin
        unique case (reg_addr)
            WORD_IRQ:  reg_rdata = {en_w, st_w};
            WORD_GPIO: reg_rdata = gpio_w;
            WORD_MISC: reg_rdata = misc_w;
            default:   reg_rdata = 32'h0;
        endcase
    end

    AST_IRQ_DROPS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_irq && reg_be[1:0] == 2'b11 && reg_wdata[15:0] == 16'hFFFF && chan_irq == 4'h0)
        |=> !host_irq); // R4
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != WORD_IRQ && reg_addr != WORD_GPIO && reg_addr != WORD_MISC)
        |-> reg_rdata == 32'h0); // R10
endmodule

// File: tb/test_bridge_irq_ctrl.sv
`timescale 1ns/1ps
module test_bridge_irq_ctrl;
    localparam int NCH = 3;
    localparam logic [15:0] POP = 16'h0043;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [3:0]  reg_be = 4'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [3:0]  chan_irq = 4'h0;
    logic        host_irq, chan_reset, mux_mode;
    logic [31:0] gpio_ctrl;

    int checks = 0;
    int failures = 0;

    logic [15:0] m_st, m_en;
    logic [31:0] m_gpio, m_misc;

    always #2 clk = ~clk;

    bridge_irq_ctrl #(.NUM_CH(NCH)) i_bridge_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .chan_irq(chan_irq), .host_irq(host_irq), .gpio_ctrl(gpio_ctrl),
        .chan_reset(chan_reset), .mux_mode(mux_mode)
    );

    function automatic logic [15:0] irq_bits(input logic [3:0] i);
        logic [15:0] v;
        v = '0;
        v[1] = i[0]; v[0] = i[1]; v[6] = i[2]; v[7] = i[3];
        return v & POP;
    endfunction

    function automatic logic [31:0] lanes(input logic [31:0] old, input logic [31:0] d,
                                          input logic [3:0] be);
        logic [31:0] r;
        r = old;
        for (int l = 0; l < 4; l++) if (be[l]) r[l*8 +: 8] = d[l*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0:    return {m_en, m_st};
            3'd6:    return m_gpio;
            3'd7:    return m_misc;
            default: return 32'h0;
        endcase
    endfunction

    // reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st <= '0; m_en <= '0; m_gpio <= '0; m_misc <= 32'h0100_0000;
        end else begin
            logic [15:0] clr;
            logic [31:0] w0;
            clr = '0;
            w0  = {m_en, 16'h0};
            if (reg_we && reg_addr == 3'd0) begin
                clr = lanes(32'h0, reg_wdata, {2'b00, reg_be[1:0]});
                w0  = lanes(w0, reg_wdata, {reg_be[3:2], 2'b00});
            end
            m_st <= (m_st & ~clr) | irq_bits(chan_irq);
            m_en <= w0[31:16] & ~(16'h00C3 & ~POP);
            if (reg_we && reg_addr == 3'd6) m_gpio <= lanes(m_gpio, reg_wdata, reg_be);
            if (reg_we && reg_addr == 3'd7) m_misc <= lanes(m_misc, reg_wdata, reg_be);
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " rdata"}, reg_rdata, exp_read(reg_addr));
        chk({tag, " R4 host_irq"}, {31'h0, host_irq}, {31'h0, |(m_st & m_en)});
        chk({tag, " R6 gpio"}, gpio_ctrl, m_gpio);
        chk({tag, " R7 reset"}, {31'h0, chan_reset}, {31'h0, m_misc[24]});
        chk({tag, " R8 mux"}, {31'h0, mux_mode}, {31'h0, ~m_misc[26]});
    endtask

    // one bus cycle, then sample 1 ns after the edge
    task automatic cyc(input logic we, input logic [2:0] a, input logic [31:0] d,
                       input logic [3:0] be, input logic [3:0] irq);
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d; reg_be = be; chan_irq = irq;
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [2:0] a, input logic [3:0] irq);
        cyc(1'b0, a, 32'h0, 4'h0, irq);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd7341));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R9 reset state
        chk("R9 irq word", reg_rdata, 32'h0);
        chk("R9 reset out", {31'h0, chan_reset}, 32'h1);
        chk("R9 mux out", {31'h0, mux_mode}, 32'h1);
        chk("R9 host_irq", {31'h0, host_irq}, 32'h0);
        rd(3'd7, 4'h0);
        chk("R9 misc word", reg_rdata, 32'h0100_0000);

        // R1 channel mapping
        rd(3'd0, 4'b0001); rd(3'd0, 4'h0);
        chk("R1 ch0 bit1", reg_rdata, 32'h0000_0002);
        cyc(1'b1, 3'd0, 32'h0000_FFFF, 4'b0011, 4'b0010); rd(3'd0, 4'h0);
        chk("R1 ch1 bit0", reg_rdata, 32'h0000_0001);
        cyc(1'b1, 3'd0, 32'h0000_FFFF, 4'b0011, 4'b0100); rd(3'd0, 4'h0);
        chk("R1 ch2 bit6", reg_rdata, 32'h0000_0040);
        cyc(1'b1, 3'd0, 32'h0000_FFFF, 4'b0011, 4'h0);

        // R5 absent channel 3 is ignored, R3 its enable stays 0
        rd(3'd0, 4'b1000); rd(3'd0, 4'h0);
        chk("R5 absent ch3 status", reg_rdata, 32'h0);
        cyc(1'b1, 3'd0, 32'hFFFF_0000, 4'b1100, 4'h0);
        chk("R3 enable readback", reg_rdata, 32'hFF7F_0000);
        rd(3'd0, 4'b1000); rd(3'd0, 4'h0);
        chk("R5 host_irq from absent channel", {31'h0, host_irq}, 32'h0);

        // R4 host irq rises and falls, R2 clear
        rd(3'd0, 4'b0100); rd(3'd0, 4'h0);
        chk("R4 host_irq set", {31'h0, host_irq}, 32'h1);
        cyc(1'b1, 3'd0, 32'h0000_00C3, 4'b0011, 4'h0);
        chk("R4 host_irq cleared", {31'h0, host_irq}, 32'h0);
        chk("R2 status cleared", reg_rdata, 32'hFF7F_0000);

        // R2 set beats clear
        rd(3'd0, 4'b0001);
        cyc(1'b1, 3'd0, 32'h0000_0002, 4'b0011, 4'b0001);
        chk("R2 set priority", reg_rdata, 32'hFF7F_0002);
        cyc(1'b1, 3'd0, 32'h0000_0001, 4'b0011, 4'h0);
        chk("R2 write 0 keeps bit", reg_rdata, 32'hFF7F_0002);

        // R6 GPIO halfword then byte
        cyc(1'b1, 3'd6, 32'h0005_0000, 4'b1100, 4'h0);
        cyc(1'b1, 3'd6, 32'hFFFF_FF00, 4'b0001, 4'h0);
        chk("R6 gpio value", gpio_ctrl, 32'h0005_0000);

        // R7 R8 reset release/hold
        cyc(1'b1, 3'd7, 32'h0400_0000, 4'b1000, 4'h0);
        chk("R7 reset released", {31'h0, chan_reset}, 32'h0);
        chk("R8 mux left", {31'h0, mux_mode}, 32'h0);
        cyc(1'b1, 3'd7, 32'h0500_0000, 4'b1000, 4'h0);
        chk("R7 reset held", {31'h0, chan_reset}, 32'h1);

        // R11 partial lanes
        cyc(1'b1, 3'd7, 32'hAABB_CCDD, 4'b0010, 4'h0);
        chk("R11 misc lane1 only", reg_rdata, 32'h0500_CC00);

        // R10 unmapped write and read
        cyc(1'b1, 3'd3, 32'hFFFF_FFFF, 4'hF, 4'h0);
        chk("R10 unmapped read", reg_rdata, 32'h0);
        rd(3'd6, 4'h0);
        chk("R10 gpio untouched", reg_rdata, 32'h0005_0000);
        rd(3'd7, 4'h0);
        chk("R10 misc untouched", reg_rdata, 32'h0500_CC00);

        // random traffic against the model
        for (int n = 0; n < 400; n++) begin
            logic [3:0] irq;
            irq = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
            cyc(1'($urandom), 3'($urandom), $urandom, 4'($urandom), irq);
            check_all("R1 R2 R3 R11 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule